// File: doc/BRIEF.md
# Bus-Watching Trigger Sequencer

This block observes each transfer on a processor bus and decides, under a 4-bit mode field, whether a debug trigger fires. Three comparators take part. Comparator A checks an address, and comparator B checks an address, a data byte and a read/write direction. Comparator C checks an address and is used only for its flag. The modes cover single-comparator triggers, logical combinations, two-step sequences in which A must come first, triggers that are qualified by data, and checks that the address falls inside or outside a window bounded by A and B.

Software works through a two-entry register port. Entry 0 is the status/control byte, which holds three sticky match flags and the mode field. Entry 1 is the arm control. Comparators are evaluated only while the unit is armed. When the selected condition is met, the unit emits a one-cycle trigger pulse and disarms itself. Software must re-arm it before another trigger can occur. Every output is registered: the trigger pulse and the read data each appear one clock after the cycle that caused them.

Top module: `dbg_trig_unit`

## Requirements
- R1: After synchronous reset, entry 0 reads 0x00, entry 1 reads 0x00 and `trig` is low.
- R2: Entry 0 reads {AF, BF, CF, 0, MODE[3:0]}, with AF at bit 7, BF at bit 6, CF at bit 5, bit 4 always 0 and the mode in bits 3:0. Writing entry 0 loads only the mode. Entry 1 reads the arm state in bit 0. `reg_rdata` returns the selected entry one clock after `reg_sel` is presented.
- R3: While armed, each flag sets on its comparator's match and stays set. AF sets when the address equals A. CF sets when the address equals C. BF sets when the address equals B, with two exceptions: in modes 3 and 4 it needs a full B event (address B, data B and direction B), and in modes 5 and 6 it needs only the data to equal B data.
- R4: A write to entry 0, or a write of 1 to entry 1 bit 0, clears all flags and the A-seen sequence state. In the cycle of any register write, comparator results are discarded and no trigger fires.
- R5: While disarmed, no flag changes except through a register write, and no trigger fires. Writing 0 to entry 1 bit 0 disarms the unit.
- R6: A firing condition in cycle n gives `trig` high for exactly cycle n+1, and the unit is disarmed from that cycle on.
- R7: Mode 0 fires on an A address match. Mode 1 fires on an A or a B address match.
- R8: Mode 2 fires on a B address match that comes after an A match recorded since arming. A B match before any A match is ignored.
- R9: Mode 3 fires on a B event, meaning a valid transfer whose address, data and read/write all equal B. An address match alone does not fire. Mode 4 fires on a B event that follows an A match.
- R10: Mode 5 fires when the address equals A and the data equals B data in the same cycle. Mode 6 fires when the address equals A and the data differs from B data.
- R11: Mode 7 fires when A ≤ address ≤ B, with both bounds inclusive. Mode 8 fires when the address is below A or above B.
- R12: Modes 9 to 15 read back as written and trigger exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Entry select: 0 status/control, 1 arm |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the selected entry |
| bus_valid | input | 1 | Bus transfer valid this cycle |
| bus_rw | input | 1 | Transfer direction, 1 = read |
| bus_addr | input | AW | Transfer address |
| bus_data | input | DW | Transfer data |
| cmp_a_addr | input | AW | Comparator A address (low bound in range modes) |
| cmp_b_addr | input | AW | Comparator B address (high bound in range modes) |
| cmp_b_data | input | DW | Comparator B data value |
| cmp_b_rw | input | 1 | Comparator B direction for B events |
| cmp_c_addr | input | AW | Comparator C address |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The collision that matters is a register write that arrives in the same cycle as a bus transfer that would otherwise match. The bench drives a status write together with an A-address transfer while armed in mode 0. It also drives an arm write of 1 together with the same transfer. In both cases it expects no trigger pulse, flags that read back as zero, and an arm bit that is still set. A plain A transfer on the following cycle must then fire, which shows the unit was left armed and not consumed.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  localparam logic [3:0] MD_A_ONLY      = 4'd0;
  localparam logic [3:0] MD_A_OR_B      = 4'd1;
  localparam logic [3:0] MD_A_THEN_B    = 4'd2;
  localparam logic [3:0] MD_EVT_B       = 4'd3;
  localparam logic [3:0] MD_A_THEN_EVTB = 4'd4;
  localparam logic [3:0] MD_A_AND_D     = 4'd5;
  localparam logic [3:0] MD_A_AND_NOT_D = 4'd6;
  localparam logic [3:0] MD_INSIDE      = 4'd7;
  localparam logic [3:0] MD_OUTSIDE     = 4'd8;

  // Per-cycle comparator results
  typedef struct packed {
    logic a;       // address == A
    logic b_addr;  // address == B
    logic b_evt;   // address, data and direction == B
    logic d_eq;    // data == B data
    logic in_rng;  // A <= address <= B
    logic out_rng; // address < A or address > B
    logic c;       // address == C
  } hits_t;

  // Reserved encodings fall back to A only
  function automatic logic [3:0] eff_mode(input logic [3:0] m);
    return (m > MD_OUTSIDE) ? MD_A_ONLY : m;
  endfunction

endpackage

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp
  import dbg_trig_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          valid,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  input  logic          b_rw,
  input  logic [AW-1:0] c_addr,
  output hits_t         hits
);

  logic eq_a, eq_b, eq_c, eq_d, ge_a, le_b;

  always_comb begin
    eq_a = (addr == a_addr);
    eq_b = (addr == b_addr);
    eq_c = (addr == c_addr);
    eq_d = (data == b_data);
    ge_a = (addr >= a_addr);
    le_b = (addr <= b_addr);

    hits.a       = valid & eq_a;
    hits.b_addr  = valid & eq_b;
    hits.b_evt   = valid & eq_b & eq_d & (rw == b_rw);
    hits.d_eq    = valid & eq_d;
    hits.in_rng  = valid & ge_a & le_b;
    hits.out_rng = valid & ~(ge_a & le_b);
    hits.c       = valid & eq_c;
  end

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
#(
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armed,
  input  logic          reg_wr,
  input  logic [MW-1:0] mode,
  input  hits_t         hits,
  output logic          fire,
  output logic          b_flag_hit,
  output logic          trig
);

  logic [3:0] em;
  logic       a_seen;
  logic       cond;
  logic       seq_mode;

  always_comb begin
    em       = eff_mode(mode[3:0]);
    seq_mode = (em == MD_A_THEN_B) || (em == MD_A_THEN_EVTB);
    cond       = 1'b0;
    b_flag_hit = hits.b_addr;
    case (em)
      MD_A_ONLY:      cond = hits.a;
      MD_A_OR_B:      cond = hits.a | hits.b_addr;
      MD_A_THEN_B:    cond = a_seen & hits.b_addr;
      MD_EVT_B: begin
        cond       = hits.b_evt;
        b_flag_hit = hits.b_evt;
      end
      MD_A_THEN_EVTB: begin
        cond       = a_seen & hits.b_evt;
        b_flag_hit = hits.b_evt;
      end
      MD_A_AND_D: begin
        cond       = hits.a & hits.d_eq;
        b_flag_hit = hits.d_eq;
      end
      MD_A_AND_NOT_D: begin
        cond       = hits.a & ~hits.d_eq;
        b_flag_hit = hits.d_eq;
      end
      MD_INSIDE:      cond = hits.in_rng;
      MD_OUTSIDE:     cond = hits.out_rng;
      default:        cond = hits.a;
    endcase
    fire = armed & ~reg_wr & cond;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_seen <= 1'b0;
      trig   <= 1'b0;
    end else begin
      trig <= fire;
      if (reg_wr || !armed || fire)
        a_seen <= 1'b0;
      else if (seq_mode && hits.a)
        a_seen <= 1'b1;
    end
  end

  // R6
  trig_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);

  // R8
  seq_mode_chk: assert property (@(posedge clk) disable iff (rst)
    a_seen |-> seq_mode);

endmodule

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs #(
  parameter int MW = 4,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [RW-1:0] reg_wdata,
  input  logic          a_hit,
  input  logic          b_hit,
  input  logic          c_hit,
  input  logic          fire,
  output logic          armed,
  output logic [MW-1:0] mode,
  output logic [RW-1:0] reg_rdata
);

  localparam int PAD = RW - MW - 4;

  logic af, bf, cf;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      mode  <= '0;
      af    <= 1'b0;
      bf    <= 1'b0;
      cf    <= 1'b0;
    end else if (reg_wr) begin
      if (!reg_sel) begin
        mode <= reg_wdata[MW-1:0];
        af   <= 1'b0;
        bf   <= 1'b0;
        cf   <= 1'b0;
      end else begin
        armed <= reg_wdata[0];
        if (reg_wdata[0]) begin
          af <= 1'b0;
          bf <= 1'b0;
          cf <= 1'b0;
        end
      end
    end else if (armed) begin
      af <= af | a_hit;
      bf <= bf | b_hit;
      cf <= cf | c_hit;
      if (fire) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_sel)
      reg_rdata <= {{(RW-1){1'b0}}, armed};
    else
      reg_rdata <= {af, bf, cf, 1'b0, {PAD{1'b0}}, mode};
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_sel |=> !reg_rdata[4]);

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && (af || bf || cf)) |=> ((af || bf || cf)));

  // R5
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && !reg_wr) |=> $stable({af, bf, cf}));

  // R4
  wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel) |=> !(af || bf || cf));

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int MW = 4,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic          bus_rw,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [AW-1:0] cmp_a_addr,
  input  logic [AW-1:0] cmp_b_addr,
  input  logic [DW-1:0] cmp_b_data,
  input  logic          cmp_b_rw,
  input  logic [AW-1:0] cmp_c_addr,
  output logic          trig
);

  hits_t         hits;
  logic          armed;
  logic          fire;
  logic          b_flag_hit;
  logic [MW-1:0] mode;

  dbg_trig_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .valid  (bus_valid),
    .rw     (bus_rw),
    .addr   (bus_addr),
    .data   (bus_data),
    .a_addr (cmp_a_addr),
    .b_addr (cmp_b_addr),
    .b_data (cmp_b_data),
    .b_rw   (cmp_b_rw),
    .c_addr (cmp_c_addr),
    .hits   (hits)
  );

  dbg_trig_seq #(.MW(MW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .armed      (armed),
    .reg_wr     (reg_wr),
    .mode       (mode),
    .hits       (hits),
    .fire       (fire),
    .b_flag_hit (b_flag_hit),
    .trig       (trig)
  );

  dbg_trig_regs #(.MW(MW), .RW(RW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .a_hit     (hits.a),
    .b_hit     (b_flag_hit),
    .c_hit     (hits.c),
    .fire      (fire),
    .armed     (armed),
    .mode      (mode),
    .reg_rdata (reg_rdata)
  );

  // R6
  disarm_on_trig_chk: assert property (@(posedge clk) disable iff (rst)
    trig |-> !armed);

  // R5
  no_fire_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed) |=> !trig);

endmodule

// File: tb/tb_dbg_trig_unit.sv
`timescale 1ns/1ps
module tb_dbg_trig_unit;

  localparam logic [15:0] AA = 16'h1000;
  localparam logic [15:0] BA = 16'h2000;
  localparam logic [15:0] CA = 16'h3000;
  localparam logic [7:0]  BD = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        bus_valid = 1'b0, bus_rw = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        trig;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int         stamp;
    bit         is_rd;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbg_trig_unit dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_valid(bus_valid), .bus_rw(bus_rw), .bus_addr(bus_addr),
    .bus_data(bus_data), .cmp_a_addr(AA), .cmp_b_addr(BA),
    .cmp_b_data(BD), .cmp_b_rw(1'b1), .cmp_c_addr(CA), .trig(trig)
  );

  // Monitor: compares results as they appear
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_rd ? reg_rdata : {7'b0, trig};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s %s actual=%02h expected=%02h cyc=%0d",
                 it.req, it.is_rd ? "rdata" : "trig", act, it.exp, cyc);
      end
    end
  end

  // Driver
  task automatic step(input bit wr, input bit sel, input logic [7:0] wd,
                      input bit v, input bit rw, input logic [15:0] a,
                      input logic [7:0] d, input bit exp_t, input bit chk,
                      input logic [7:0] exp_r, input string req);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    bus_valid = v; bus_rw = rw; bus_addr = a; bus_data = d;
    q.push_back('{cyc + 1, 1'b0, {7'b0, exp_t}, req});
    if (chk) q.push_back('{cyc + 1, 1'b1, exp_r, req});
  endtask

  task automatic wr_stat(input logic [7:0] v, input string req);
    step(1, 0, v, 0, 0, 16'h0, 8'h0, 0, 0, 8'h0, req);
  endtask
  task automatic arm(input string req);
    step(1, 1, 8'h01, 0, 0, 16'h0, 8'h0, 0, 0, 8'h0, req);
  endtask
  task automatic bus(input logic [15:0] a, input logic [7:0] d, input bit rw,
                     input bit exp_t, input string req);
    step(0, 0, 8'h0, 1, rw, a, d, exp_t, 0, 8'h0, req);
  endtask
  task automatic rd(input bit sel, input logic [7:0] exp_r, input string req);
    step(0, sel, 8'h0, 0, 0, 16'h0, 8'h0, 0, 1, exp_r, req);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired actual=hang expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 8'h00, "R1");
    rd(1, 8'h00, "R1");

    // R5 disarmed: no trigger, no flags
    bus(AA, 8'h0, 0, 0, "R5");
    bus(CA, 8'h0, 0, 0, "R5");
    rd(0, 8'h00, "R5");

    // R2 bit 4 and flag bits not writable through entry 0
    wr_stat(8'hF3, "R2");
    rd(0, 8'h03, "R2");

    // R7 mode 0
    wr_stat(8'h00, "R7");
    arm("R7");
    rd(1, 8'h01, "R2");
    bus(BA, 8'h0, 0, 0, "R7");
    bus(AA, 8'h0, 0, 1, "R7");
    bus(AA, 8'h0, 0, 0, "R6");
    rd(0, 8'hC0, "R3");
    rd(1, 8'h00, "R6");

    // R7 mode 1, R3 sticky C flag, R4 clear on status write
    wr_stat(8'h01, "R7");
    arm("R7");
    bus(CA, 8'h0, 0, 0, "R7");
    rd(0, 8'h21, "R3");
    bus(16'h4444, 8'h0, 0, 0, "R3");
    rd(0, 8'h21, "R3");
    bus(BA, 8'h0, 0, 1, "R7");
    rd(0, 8'h61, "R3");
    wr_stat(8'h01, "R4");
    rd(0, 8'h01, "R4");

    // R8 A then B
    wr_stat(8'h02, "R8");
    arm("R8");
    bus(BA, 8'h0, 0, 0, "R8");
    bus(AA, 8'h0, 0, 0, "R8");
    bus(16'h4444, 8'h0, 0, 0, "R8");
    bus(BA, 8'h0, 0, 1, "R8");

    // R9 event only B
    wr_stat(8'h03, "R9");
    arm("R9");
    bus(BA, 8'h00, 1, 0, "R9");
    bus(BA, BD, 0, 0, "R9");
    rd(0, 8'h03, "R9");
    bus(BA, BD, 1, 1, "R9");
    rd(0, 8'h43, "R9");

    // R9 A then event B
    wr_stat(8'h04, "R9");
    arm("R9");
    bus(BA, BD, 1, 0, "R9");
    bus(AA, 8'h0, 0, 0, "R9");
    bus(BA, BD, 1, 1, "R9");

    // R10 full modes
    wr_stat(8'h05, "R10");
    arm("R10");
    bus(AA, 8'h00, 0, 0, "R10");
    bus(AA, BD, 0, 1, "R10");
    wr_stat(8'h06, "R10");
    arm("R10");
    bus(AA, BD, 0, 0, "R10");
    bus(AA, 8'h11, 0, 1, "R10");

    // R11 inside range, inclusive bounds
    wr_stat(8'h07, "R11");
    arm("R11");
    bus(16'h0FFF, 8'h0, 0, 0, "R11");
    bus(AA, 8'h0, 0, 1, "R11");
    arm("R11");
    bus(BA, 8'h0, 0, 1, "R11");
    arm("R11");
    bus(16'h2001, 8'h0, 0, 0, "R11");

    // R11 outside range
    wr_stat(8'h08, "R11");
    arm("R11");
    bus(16'h1500, 8'h0, 0, 0, "R11");
    bus(AA, 8'h0, 0, 0, "R11");
    bus(BA, 8'h0, 0, 0, "R11");
    bus(16'h2001, 8'h0, 0, 1, "R11");
    arm("R11");
    bus(16'h0FFF, 8'h0, 0, 1, "R11");

    // R12 reserved codes
    wr_stat(8'h0B, "R12");
    rd(0, 8'h0B, "R12");
    arm("R12");
    bus(BA, 8'h0, 0, 0, "R12");
    bus(AA, 8'h0, 0, 1, "R12");
    wr_stat(8'h0F, "R12");
    arm("R12");
    bus(AA, 8'h0, 0, 1, "R12");

    // R4 register write collides with a matching transfer
    wr_stat(8'h00, "R4");
    arm("R4");
    step(1, 0, 8'h00, 1, 0, AA, 8'h0, 0, 0, 8'h0, "R4");
    rd(0, 8'h00, "R4");
    rd(1, 8'h01, "R4");
    step(1, 1, 8'h01, 1, 0, AA, 8'h0, 0, 0, 8'h0, "R4");
    rd(0, 8'h00, "R4");
    bus(AA, 8'h0, 0, 1, "R4");

    // R5 disarm by writing 0
    arm("R5");
    step(1, 1, 8'h00, 0, 0, 16'h0, 8'h0, 0, 0, 8'h0, "R5");
    bus(AA, 8'h0, 0, 0, "R5");
    rd(1, 8'h00, "R5");
    rd(0, 8'h00, "R5");

    step(0, 0, 8'h0, 0, 0, 16'h0, 8'h0, 0, 0, 8'h0, "R6");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6 pending items actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule